// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter

This block turns the single-bit output of a delta-sigma modulator into signed multi-bit samples. Each accepted bit is weighted as +1 (one) or −1 (zero). The weighted bits pass through three cascaded integrators running at the bit rate and then three comb differencers running at the decimated rate. The result is a sinc³ low-pass response with a run-time oversampling ratio R. A ones density of one half therefore reads as zero. For a steady pattern, the output settles to R³·(2·density − 1). With this scaling, 80 % ones maps to +0.6·R³ and 20 % ones maps to −0.6·R³.

The filter runs on the modulator clock and accepts a bit on every cycle in which the bit strobe is high. Cycles without the strobe are skipped entirely, so a stream with gaps gives the same samples as a continuous one. For each sample there is a one-cycle valid pulse and a settled flag. The settled flag stays low until the comb history holds only data taken at the current ratio.

Top module: `sd_sinc3_decim`

## Requirements
- R1: A bit value 1 is weighted +1 and a bit value 0 is weighted −1. For a repeating pattern of period n that divides R, each settled sample equals R³·(2·ones − n)/n, so alternating bits give exactly 0.
- R2: More ones give a positive sample. At R = 20, a pattern with 4 ones in 5 bits settles to +4800 and a pattern with 1 one in 5 bits settles to −4800.
- R3: Full scale is exact at every ratio. All ones give +R³ and all zeros give −R³, including +16777216 at R = 256 on the 26-bit output, even though the integrators wrap internally.
- R4: `sample_valid_o` is high for exactly one cycle for each R accepted bits. The pulse comes in the cycle after the clock edge that takes the R-th bit, and `sample_o` changes only together with such a pulse.
- R5: A cycle with `bit_valid_i` low has no effect on the filter state or on the bit count. A stream with idle cycles between bits gives the same samples and the same bits-per-sample spacing as the same stream without them.
- R6: The requested ratio is clamped to the range 16 to 256. Requests of 0 or 5 act as 16, and a request of 300 acts as 256.
- R7: When the clamped request differs from the ratio in force, the new ratio takes effect on the next edge and the bit counter restarts. The next pulse then comes after exactly R new bits, whatever part of a frame had already been taken.
- R8: The first three samples after reset or after a ratio change have `sample_settled_o` low. From the fourth sample on, the flag is high and the sample value is exact.
- R9: During and right after reset, `sample_o` is 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bit_valid_i | input | 1 | High when `bit_i` holds a new modulator bit |
| bit_i | input | 1 | Modulator output bit |
| ratio_i | input | 9 | Requested decimation ratio (clamped to 16..256) |
| sample_o | output | 26 | Signed filtered sample, two's complement |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| sample_settled_o | output | 1 | Sample comes from a fully filled filter at the current ratio |

## Verification
The filter is driven with periodic ones patterns whose period divides R, so every settled sample has a closed-form value. The patterns used are alternating bits, the 80 % and 20 % patterns, 75 % and 87.5 % patterns, and all ones and all zeros. Together they separate a wrong bit weight or sign, a wrong gain, and a wrong wrap width (the R = 256 full-scale case). A 75 % stream is repeated with an idle cycle before every bit to show that skipped cycles leave the result unchanged. Out-of-range ratio requests and a ratio change in mid-frame are told apart by counting accepted bits between pulses. The settled flag is checked on every pulse.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int SINC_ORDER = 3;

    // Warm-up progress: number of samples emitted since the last restart
    typedef enum logic [1:0] {
        WARM_A    = 2'd0,
        WARM_B    = 2'd1,
        WARM_C    = 2'd2,
        WARM_DONE = 2'd3
    } warm_e;

    // Output flags carried from the controller to the top
    typedef struct packed {
        logic valid;
        logic settled;
    } flags_t;

    function automatic int unsigned clamp_ratio(input int unsigned req,
                                                input int unsigned lo,
                                                input int unsigned hi);
        if (req < lo)      return lo;
        else if (req > hi) return hi;
        else               return req;
    endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int W     = 26,
    parameter int ORDER = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                en_i,
    input  logic                bit_i,
    output logic signed [W-1:0] tail_o
);
    logic signed [W-1:0] acc_q [ORDER];
    logic signed [W-1:0] acc_d [ORDER];
    logic signed [W-1:0] step;

    // +1 for a one, -1 (all ones) for a zero
    assign step = bit_i ? W'(1) : {W{1'b1}};

    always_comb begin
        acc_d[0] = acc_q[0] + step;
        for (int k = 1; k < ORDER; k++) begin
            acc_d[k] = acc_q[k] + acc_d[k-1];
        end
    end

    assign tail_o = acc_d[ORDER-1];

    for (genvar st = 0; st < ORDER; st++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i)     acc_q[st] <= '0;
            else if (en_i) acc_q[st] <= acc_d[st];
        end

        // R5: an idle cycle leaves every integrator untouched
        a_r5_integ_hold: assert property (@(posedge clk_i) disable iff (rst_i)
            !en_i |=> $stable(acc_q[st]));
    end

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int W     = 26,
    parameter int ORDER = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                fire_i,
    input  logic signed [W-1:0] in_i,
    output logic signed [W-1:0] out_o
);
    logic signed [W-1:0] dly_q [ORDER];
    logic signed [W-1:0] diff  [ORDER];

    always_comb begin
        diff[0] = in_i - dly_q[0];
        for (int k = 1; k < ORDER; k++) begin
            diff[k] = diff[k-1] - dly_q[k];
        end
    end

    for (genvar st = 0; st < ORDER; st++) begin : g_stage
        if (st == 0) begin : g_head
            always_ff @(posedge clk_i) begin
                if (rst_i)       dly_q[st] <= '0;
                else if (fire_i) dly_q[st] <= in_i;
            end
        end else begin : g_body
            always_ff @(posedge clk_i) begin
                if (rst_i)       dly_q[st] <= '0;
                else if (fire_i) dly_q[st] <= diff[st-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)       out_o <= '0;
        else if (fire_i) out_o <= diff[ORDER-1];
    end

    // R4: the sample only moves on a decimation point
    a_r4_out_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !fire_i |=> $stable(out_o));

endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
    import sinc3_pkg::*;
#(
    parameter int MIN_RATIO = 16,
    parameter int MAX_RATIO = 256,
    parameter int RATIO_W   = 9
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               bit_valid_i,
    input  logic [RATIO_W-1:0] ratio_req_i,
    output logic               fire_o,
    output flags_t             flags_o
);
    localparam int CNT_W = $clog2(MAX_RATIO);

    logic [RATIO_W-1:0] ratio_eff;
    logic [RATIO_W-1:0] ratio_q;
    logic [CNT_W-1:0]   cnt_q;
    warm_e              warm_q;
    logic               restart;
    logic               last;

    assign ratio_eff = RATIO_W'(clamp_ratio(32'(ratio_req_i),
                                            MIN_RATIO, MAX_RATIO));
    assign restart   = (ratio_eff != ratio_q);
    assign last      = (RATIO_W'(cnt_q) == ratio_q - RATIO_W'(1));
    assign fire_o    = bit_valid_i && !restart && last;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ratio_q         <= RATIO_W'(MIN_RATIO);
            cnt_q           <= '0;
            warm_q          <= WARM_A;
            flags_o.valid   <= 1'b0;
            flags_o.settled <= 1'b0;
        end else begin
            flags_o.valid   <= fire_o;
            flags_o.settled <= fire_o && (warm_q == WARM_DONE);
            if (restart) begin
                ratio_q <= ratio_eff;
                cnt_q   <= '0;
                warm_q  <= WARM_A;
            end else if (bit_valid_i) begin
                cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
                if (last && warm_q != WARM_DONE) begin
                    warm_q <= warm_e'(warm_q + 2'd1);
                end
            end
        end
    end

    // R4: counter never reaches the ratio
    a_r4_count_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        RATIO_W'(cnt_q) < ratio_q);

    // R4: a sample strobe lasts one cycle (ratio is at least 16)
    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        flags_o.valid |=> !flags_o.valid);

    // R5: a strobe always follows an accepted bit
    a_r5_pulse_needs_bit: assert property (@(posedge clk_i) disable iff (rst_i)
        flags_o.valid |-> $past(bit_valid_i));

    // R8: settled is only ever raised alongside a sample
    a_r8_settled_with_valid: assert property (@(posedge clk_i) disable iff (rst_i)
        flags_o.settled |-> flags_o.valid);

endmodule

// File: rtl/sd_sinc3_decim.sv
module sd_sinc3_decim
    import sinc3_pkg::*;
#(
    parameter  int MIN_RATIO = 16,
    parameter  int MAX_RATIO = 256,
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1),
    localparam int ACC_W     = SINC_ORDER * $clog2(MAX_RATIO) + 2
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    bit_valid_i,
    input  logic                    bit_i,
    input  logic [RATIO_W-1:0]      ratio_i,
    output logic signed [ACC_W-1:0] sample_o,
    output logic                    sample_valid_o,
    output logic                    sample_settled_o
);
    logic                    fire;
    flags_t                  flags;
    logic signed [ACC_W-1:0] tail;

    sinc3_ctrl #(
        .MIN_RATIO (MIN_RATIO),
        .MAX_RATIO (MAX_RATIO),
        .RATIO_W   (RATIO_W)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bit_valid_i (bit_valid_i),
        .ratio_req_i (ratio_i),
        .fire_o      (fire),
        .flags_o     (flags)
    );

    sinc3_integ #(
        .W     (ACC_W),
        .ORDER (SINC_ORDER)
    ) u_integ (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (bit_valid_i),
        .bit_i  (bit_i),
        .tail_o (tail)
    );

    sinc3_comb #(
        .W     (ACC_W),
        .ORDER (SINC_ORDER)
    ) u_comb (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .fire_i (fire),
        .in_i   (tail),
        .out_o  (sample_o)
    );

    assign sample_valid_o   = flags.valid;
    assign sample_settled_o = flags.settled;

endmodule

// File: tb/tb_sd_sinc3_decim.sv
`timescale 1ns/1ps
module tb_sd_sinc3_decim;
    localparam int ACC_W = 26;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    bv  = 1'b0;
    logic                    bt  = 1'b0;
    logic [8:0]              ratio = 9'd16;
    logic signed [ACC_W-1:0] sample;
    logic                    sv, ss;

    sd_sinc3_decim dut (
        .clk_i            (clk),
        .rst_i            (rst),
        .bit_valid_i      (bv),
        .bit_i            (bt),
        .ratio_i          (ratio),
        .sample_o         (sample),
        .sample_valid_o   (sv),
        .sample_settled_o (ss)
    );

    always #2 clk = ~clk;

    int     n_chk = 0;
    int     n_bad = 0;
    int     cyc   = 0;
    bit     done  = 0;
    int     bits_since = 0;
    int     pulses = 0;
    bit     saw = 0;
    longint last_sample = 0;
    bit     last_settled = 0;
    int     last_spacing = 0;
    int     exp_r = 0;
    longint exp_val = 0;
    string  cur_tag = "";

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    // Observe outputs, then drive the next inputs, away from the rising edge
    task automatic step(input logic v, input logic b);
        @(negedge clk);
        saw = sv;
        if (sv) begin
            last_sample  = longint'(sample);
            last_settled = ss;
            last_spacing = bits_since;
            bits_since   = 0;
            pulses++;
        end
        bv = v;
        bt = b;
        if (v) bits_since++;
    endtask

    task automatic judge();
        if (saw) begin
            chk("R4 spacing", last_spacing, exp_r);
            if (pulses <= 3) begin
                chk("R8 early settled", last_settled, 0);
            end else begin
                chk("R8 settled", last_settled, 1);
                chk(cur_tag, last_sample, exp_val);
            end
        end
    endtask

    task automatic do_reset(input logic [8:0] req);
        ratio = req;
        rst = 1'b1;
        step(0, 0);
        step(0, 0);
        rst = 1'b0;
        step(0, 0);
        step(0, 0);
        bits_since = 0;
        pulses = 0;
    endtask

    task automatic run(input logic [8:0] req, input int r, input logic [31:0] pat,
                       input int period, input int nout, input bit gap,
                       input string tag);
        int ones = 0;
        int k = 0;
        for (int i = 0; i < period; i++) ones += int'(pat[i]);
        exp_r   = r;
        exp_val = longint'(r) * r * r * (2 * ones - period) / period;
        cur_tag = tag;
        do_reset(req);
        while (pulses < nout && k < nout * r + 16) begin
            if (gap) begin
                step(0, 0);
                judge();
            end
            step(1, pat[k % period]);
            judge();
            k++;
        end
        step(0, 0);
        judge();
        chk({tag, " pulse count"}, pulses, nout);
    endtask

    initial begin
        // R9: reset state
        step(0, 0);
        step(0, 0);
        chk("R9 sample", longint'(sample), 0);
        chk("R9 valid", sv, 0);
        chk("R9 settled", ss, 0);

        run(9'd16,  16,  32'b10,       2, 6, 0, "R1 half density");
        run(9'd16,  16,  32'b1,        1, 5, 0, "R3 all ones r16");
        run(9'd16,  16,  32'b0,        1, 5, 0, "R3 all zeros r16");
        run(9'd20,  20,  32'b01111,    5, 5, 0, "R2 eighty percent");
        run(9'd20,  20,  32'b00001,    5, 5, 0, "R2 twenty percent");
        run(9'd16,  16,  32'b0111,     4, 5, 1, "R5 gapped stream");
        run(9'd5,   16,  32'b1,        1, 5, 0, "R6 low clamp");
        run(9'd0,   16,  32'b10,       2, 5, 0, "R6 zero clamp");
        run(9'd300, 256, 32'h7F,       8, 4, 0, "R6 high clamp");
        run(9'd256, 256, 32'b1,        1, 5, 0, "R3 all ones r256");

        // R7: ratio change in mid-frame restarts the count
        do_reset(9'd16);
        for (int i = 0; i < 7; i++) step(1, 1);
        ratio = 9'd32;
        step(0, 0);
        step(0, 0);
        chk("R7 no early pulse", pulses, 0);
        bits_since = 0;
        begin
            int guard = 0;
            while (pulses == 0 && guard < 100) begin
                step(1, 1);
                guard++;
            end
        end
        chk("R7 spacing after change", last_spacing, 32);
        chk("R7 unsettled after change", last_settled, 0);

        finish_run();
    end

endmodule